// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines and, on every clock, picks the most urgent request among those that are raised, enabled and given a nonzero level. It then presents a packet for the winner on a valid/data output. The packet carries a computed handler address, the requested interrupt level, the requested shadow register set and a non-maskable flag. A processor-side consumer can use the packet directly to jump to the handler and switch register sets, without any software polling to find the cause.

Each line has its own configuration word, written through a small register port: a level, a register-set index, a non-maskable flag and an enable bit. Two global registers set the vector base and the spacing between handler entries. A chain input accepts the same packet from an upstream controller. The block forwards whichever of the local winner and the chained packet is more urgent, so that the controller nearest the processor presents the best request of the whole chain.

Top module: `vic_core`

## Requirements
- R1: After reset the output valid is low, every line configuration word reads 0 (all lines disabled), the vector base reads 0 and the spacing code reads 0.
- R2: A line takes part in arbitration only if its request input is high, its enable bit (config bit 24) is set and its level field (config bits 5:0) is nonzero.
- R3: A candidate whose non-maskable flag (config bit 16) is set beats every maskable candidate, whatever their levels.
- R4: Among candidates of equal non-maskable flag, the higher level wins. On equal flag and level, the lower line index wins.
- R5: The handler address of a local winner is base + index * (16 << s), where s is the spacing code (register 1, bits 2:0) and codes 6 and 7 act as 5, giving spacings of 16 to 512 bytes.
- R6: When the chain input is valid, its packet is forwarded unchanged if its key {nmi, level} is strictly greater than the best local key, or if there is no local candidate. On an equal key the local winner is presented.
- R7: The output fields are registered: a change at the request, chain or configuration inputs shows at the output one clock edge later and not before.
- R8: The output valid is high exactly when, one edge earlier, a local candidate existed or the chain input was valid. The level, register set (config bits 13:8) and flag fields are those of the winner.
- R9: Register 2 reads the raw request lines, bit i for line i. Register 3 reads the registered winner: bit 8 is set when the output is valid and comes from a local line, and bits 4:0 give that line's index.
- R10: Line configuration words live at register 0x20 + i and read back the written level, register set, flag and enable fields. Register 0 holds the vector base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | N_IRQ | Level-sensitive request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| chn_valid | input | 1 | Upstream packet valid |
| chn_addr | input | 32 | Upstream handler address |
| chn_level | input | LVL_W | Upstream requested level |
| chn_rset | input | RS_W | Upstream register set |
| chn_nmi | input | 1 | Upstream non-maskable flag |
| out_valid | output | 1 | Packet valid |
| out_addr | output | 32 | Handler address |
| out_level | output | LVL_W | Requested level |
| out_rset | output | RS_W | Requested register set |
| out_nmi | output | 1 | Non-maskable flag |

## Verification
The bench builds the block with N_IRQ = 8 and the default 6-bit level and register-set fields. With eight lines, every one of the 256 request patterns can be swept under several per-line configurations: one that mixes disabled lines, a zero level and a non-maskable line, and one that is full of level ties. Every arbitration outcome, tie and eligibility rule is then checked against an arithmetic model. The chain input is swept over levels and flags against chosen local patterns, and all eight spacing codes are stepped through to cover the clamped codes.

// File: rtl/vic_core.sv
module vic_core #(
  parameter int N_IRQ = 32,
  parameter int LVL_W = 6,
  parameter int RS_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq,
  input  logic             reg_wr,
  input  logic [6:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             chn_valid,
  input  logic [31:0]      chn_addr,
  input  logic [LVL_W-1:0] chn_level,
  input  logic [RS_W-1:0]  chn_rset,
  input  logic             chn_nmi,
  output logic             out_valid,
  output logic [31:0]      out_addr,
  output logic [LVL_W-1:0] out_level,
  output logic [RS_W-1:0]  out_rset,
  output logic             out_nmi
);
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam int KEY_W = LVL_W + 1;

  logic [LVL_W-1:0] lvl  [N_IRQ];
  logic [RS_W-1:0]  rset [N_IRQ];
  logic             nmi  [N_IRQ];
  logic             en   [N_IRQ];
  logic [31:0]      vbase;
  logic [2:0]       scode;

  logic             loc_found, chn_win, win_local;
  logic [IDX_W-1:0] best_idx, win_idx;
  logic [KEY_W-1:0] best_key;
  logic [2:0]       shamt;
  logic [31:0]      loc_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbase <= '0;
      scode <= '0;
      for (int i = 0; i < N_IRQ; i++) begin
        lvl[i] <= '0; rset[i] <= '0; nmi[i] <= 1'b0; en[i] <= 1'b0;
      end
    end else if (reg_wr) begin
      if (reg_addr == 7'd0) vbase <= reg_wdata;
      if (reg_addr == 7'd1) scode <= reg_wdata[2:0];
      for (int i = 0; i < N_IRQ; i++)
        if (reg_addr == 7'(32 + i)) begin
          lvl[i]  <= reg_wdata[LVL_W-1:0];
          rset[i] <= reg_wdata[8 +: RS_W];
          nmi[i]  <= reg_wdata[16];
          en[i]   <= reg_wdata[24];
        end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      7'd0: reg_rdata = vbase;
      7'd1: reg_rdata = {29'd0, scode};
      7'd2: reg_rdata = 32'(irq);
      7'd3: reg_rdata = {23'd0, win_local, 3'd0, 5'(win_idx)};
      default:
        for (int i = 0; i < N_IRQ; i++)
          if (reg_addr == 7'(32 + i))
            reg_rdata = {7'd0, en[i], 7'd0, nmi[i], 8'(rset[i]), 8'(lvl[i])};
    endcase
  end

  always_comb begin
    loc_found = 1'b0;
    best_key  = '0;
    best_idx  = '0;
    for (int i = 0; i < N_IRQ; i++)
      if (irq[i] && en[i] && lvl[i] != '0 &&
          (!loc_found || {nmi[i], lvl[i]} > best_key)) begin
        loc_found = 1'b1;
        best_key  = {nmi[i], lvl[i]};
        best_idx  = IDX_W'(i);
      end
  end

  assign chn_win  = chn_valid && (!loc_found || {chn_nmi, chn_level} > best_key);
  assign shamt    = (scode > 3'd5) ? 3'd5 : scode;
  assign loc_addr = vbase + (32'(best_idx) << (32'd4 + 32'(shamt)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_addr <= '0; out_level <= '0; out_rset <= '0;
      out_nmi <= 1'b0; win_local <= 1'b0; win_idx <= '0;
    end else begin
      out_valid <= loc_found || chn_valid;
      win_local <= loc_found && !chn_win;
      win_idx   <= best_idx;
      if (chn_win) begin
        out_addr <= chn_addr; out_level <= chn_level;
        out_rset <= chn_rset; out_nmi <= chn_nmi;
      end else begin
        out_addr <= loc_addr; out_level <= lvl[best_idx];
        out_rset <= rset[best_idx]; out_nmi <= nmi[best_idx];
      end
    end
  end

  // R8
  chain_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chn_valid |=> out_valid);
  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chn_valid && irq == '0) |=> !out_valid);
  // R3
  nmi_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chn_valid && chn_nmi) |=> out_nmi);
  // R6
  chain_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chn_valid && !chn_nmi) |=> (out_nmi || out_level >= $past(chn_level)));
  // R9
  local_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_local |-> out_valid && out_level != '0);
endmodule

// File: tb/vic_core_tb.sv
module vic_core_tb;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [N-1:0] irq = '0;
  logic reg_wr = 0; logic [6:0] reg_addr = '0; logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic chn_valid = 0; logic [31:0] chn_addr = '0; logic [5:0] chn_level = '0;
  logic [5:0] chn_rset = '0; logic chn_nmi = 0;
  logic out_valid; logic [31:0] out_addr; logic [5:0] out_level, out_rset; logic out_nmi;

  vic_core #(.N_IRQ(N)) u_dut (.*);

  int total = 0, bad = 0;
  logic [5:0] m_lvl [N]; logic [5:0] m_rs [N]; logic m_nmi [N]; logic m_en [N];
  logic [31:0] m_base = '0; logic [2:0] m_code = '0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic cfg(int i, logic [5:0] l, logic [5:0] r, logic n, logic e);
    m_lvl[i] = l; m_rs[i] = r; m_nmi[i] = n; m_en[i] = e;
    wr(7'(32 + i), {7'd0, e, 7'd0, n, 2'd0, r, 2'd0, l});
  endtask

  task automatic expect_out(string r);
    logic found, cw; int bi; logic [6:0] bk; int sp;
    logic [31:0] ea; logic [5:0] el, er; logic en_;
    found = 0; bi = 0; bk = '0;
    for (int i = 0; i < N; i++)
      if (irq[i] && m_en[i] && m_lvl[i] != 0 && (!found || {m_nmi[i], m_lvl[i]} > bk)) begin
        found = 1; bi = i; bk = {m_nmi[i], m_lvl[i]};
      end
    cw = chn_valid && (!found || {chn_nmi, chn_level} > bk);
    sp = (m_code > 5) ? 5 : int'(m_code);
    if (cw) begin ea = chn_addr; el = chn_level; er = chn_rset; en_ = chn_nmi; end
    else begin ea = m_base + 32'(bi) * (32'd16 << sp); el = m_lvl[bi]; er = m_rs[bi]; en_ = m_nmi[bi]; end
    @(negedge clk);
    chk({r, " valid"}, 32'(out_valid), 32'(found || chn_valid));
    if (found || chn_valid) begin
      chk({r, " addr"}, out_addr, ea);
      chk({r, " level"}, 32'(out_level), 32'(el));
      chk({r, " rset"}, 32'(out_rset), 32'(er));
      chk({r, " nmi"}, 32'(out_nmi), 32'(en_));
    end
    reg_addr = 7'd3; #1;
    chk({r, " R9 status local"}, 32'(reg_rdata[8]), 32'(found && !cw));
    if (found && !cw) chk({r, " R9 status idx"}, 32'(reg_rdata[4:0]), 32'(bi));
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_lvl[i] = 0; m_rs[i] = 0; m_nmi[i] = 0; m_en[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(out_valid), 0);
    reg_addr = 7'h23; #1; chk("R1 line cfg after reset", reg_rdata, 0);
    reg_addr = 7'd0;  #1; chk("R1 base after reset", reg_rdata, 0);
    reg_addr = 7'd1;  #1; chk("R1 code after reset", reg_rdata, 0);

    m_base = 32'h0001_0000; wr(7'd0, m_base);
    m_code = 3'd2; wr(7'd1, 32'(m_code));
    reg_addr = 7'd0; #1; chk("R10 base readback", reg_rdata, m_base);
    // config A: line0 level 0, line5 disabled, line6 non-maskable
    for (int i = 0; i < N; i++) cfg(i, 6'((i * 5) % 7), 6'(i + 1), i == 6, i != 5);
    reg_addr = 7'h26; #1; chk("R10 cfg readback", reg_rdata, {7'd0, 1'b1, 7'd0, 1'b1, 8'd7, 8'd2});

    for (int p = 0; p < 256; p++) begin
      irq = 8'(p);
      reg_addr = 7'd2; #1; chk("R9 raw lines", reg_rdata, 32'(p));
      expect_out("R2 R3 R4 R5 R8 sweepA");
    end

    // R7: output holds until the edge
    @(negedge clk); irq = 8'h08; @(negedge clk);
    irq = 8'h10; #1;
    chk("R7 before edge", out_addr, m_base + 32'd3 * 64);
    expect_out("R7 after edge");

    // config B: all maskable, level ties
    for (int i = 0; i < N; i++) cfg(i, 6'((i % 3) + 1), 6'(40 + i), 0, 1);
    for (int p = 0; p < 256; p++) begin
      irq = 8'(p); expect_out("R4 sweepB ties");
    end

    // chain sweep
    chn_addr = 32'hCAFE_0000; chn_rset = 6'd33;
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 4; p++) begin
        chn_valid = 1; chn_level = 6'(c % 4); chn_nmi = c >= 8;
        if (c % 8 >= 4) chn_level = chn_level + 6'd1;
        irq = (p == 0) ? 8'h00 : (p == 1) ? 8'h01 : (p == 2) ? 8'h24 : 8'hFF;
        expect_out("R6 chain");
      end
    end
    chn_valid = 0;

    // spacing codes with line 7 (level 2 in config B)
    irq = 8'h80;
    for (int s = 0; s < 8; s++) begin
      m_code = 3'(s); wr(7'd1, 32'(s));
      expect_out("R5 spacing");
    end

    // line disabled / level zero ignored
    cfg(7, 6'd0, 6'd1, 0, 1);
    expect_out("R2 level zero");
    cfg(7, 6'd9, 6'd1, 0, 0);
    expect_out("R2 disabled");
    cfg(7, 6'd9, 6'd1, 0, 1);
    expect_out("R2 re-enabled");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule